// File: doc/BRIEF.md
# Serial Shift Slice with Word-Swap Buffer

This block is one lane of a programmable serial I/O engine. A 32-bit shift word moves one place to the right on every shift tick. The bit arriving on the serial input enters at the top, and the bottom bit drives the serial output. The shift tick is not a separate clock. A 12-bit down counter produces it as a one-cycle enable on the base clock, and a reload value sets the rate.

An 8-bit word counter counts shift ticks. Each time it wraps, the live shift word and a 32-bit buffer word exchange their contents. Software therefore refills or drains the buffer while the previous word is still shifting, and the stream has no gap at word boundaries.

Software configures and observes the lane through a small register port. It can preload both counters, so the first tick and the first swap fall where it chooses. The lane enable stops all hardware activity, but register writes still take effect.

Top module: `serial_shift_slice`

## Requirements
- R1: After reset, every register reads as zero and `ser_out` is 0.
- R2: On a shift tick that is not a swap tick, the shift word (address 0) becomes `{ser_in, word[31:1]}`.
- R3: `ser_out` always equals bit 0 of the shift word.
- R4: While enabled, the rate counter (address 3) decrements on every base clock cycle. In a cycle where it is zero it reloads the rate reload value (address 2) and produces a shift tick. Ticks therefore come every reload+1 cycles.
- R5: The word counter (address 5) decrements on each shift tick. On a tick where it is zero it reloads the word reload value (address 4).
- R6: On a tick where the word counter is zero, the shift word takes the old buffer word (address 1). In the same cycle, the buffer takes `{ser_in, word[31:1]}`.
- R7: While `slice_en` is low, neither counter nor either data word changes, except by register writes.
- R8: A register write overrides the hardware update of the same register in that cycle.
- R9: Addresses 2 and 3 store the low 12 bits of a write and read bits 31:12 as zero. Addresses 4 and 5 store the low 8 bits and read bits 31:8 as zero.
- R10: Addresses 6 and 7 read as zero, and a write to them changes no register.
- R11: Software can write the rate counter while the lane is disabled. After enabling, the first tick occurs on the (value+1)-th enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slice_en | input | 1 | Lane enable for counting, shifting and swapping |
| ser_in | input | 1 | Serial data in, sampled on shift ticks |
| ser_out | output | 1 | Serial data out, bit 0 of the shift word |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from the selected register |

## Verification
Every register, and with it `ser_out`, changes on the rising edge of the cycle in which its tick, swap or write was present. It is visible from that edge on. `cfg_rdata` follows `cfg_addr` within the same cycle. The bench changes inputs on the falling edge and samples 3 ns later, before the next rising edge. Each sample is compared with a requirement-level model that advances once per rising edge. The directed sequences count edges explicitly: for example, a rate counter preloaded with 2 produces its first shift on the third enabled edge, and the next ones follow every reload+1 edges.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

    localparam int WORD_W  = 32;
    localparam int RATE_W  = 12;
    localparam int SPAN_W  = 8;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_WORD      = 3'd0,
        SEL_BUFFER    = 3'd1,
        SEL_RATE_RLD  = 3'd2,
        SEL_RATE_CNT  = 3'd3,
        SEL_SPAN_RLD  = 3'd4,
        SEL_SPAN_CNT  = 3'd5,
        SEL_SPARE6    = 3'd6,
        SEL_SPARE7    = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/ssl_rate_div.sv
module ssl_rate_div #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rld_wr,
    input  logic          cnt_wr,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] rld_q,
    output logic [CW-1:0] cnt_q,
    output logic          tick
);

    typedef struct packed {
        logic [CW-1:0] rld;
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = en && (st_q.cnt == '0);
        if (en) begin
            if (st_q.cnt == '0) st_d.cnt = st_q.rld;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
        if (rld_wr) st_d.rld = wr_val;
        if (cnt_wr) st_d.cnt = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rld_q = st_q.rld;
    assign cnt_q = st_q.cnt;

    // R4: reload at zero, decrement otherwise
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q == '0 && !cnt_wr) |=> cnt_q == $past(rld_q));
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q != '0 && !cnt_wr) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R7: idle while disabled
    a_r7_rate_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt_q));
    // R8: software write wins
    a_r8_rate_write: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wr_val));

endmodule

// File: rtl/ssl_span_ctr.sv
module ssl_span_ctr #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rld_wr,
    input  logic          cnt_wr,
    input  logic [PW-1:0] wr_val,
    output logic [PW-1:0] rld_q,
    output logic [PW-1:0] cnt_q,
    output logic          wrap
);

    typedef struct packed {
        logic [PW-1:0] rld;
        logic [PW-1:0] cnt;
    } span_st_t;

    span_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == '0);
        if (tick) begin
            if (st_q.cnt == '0) st_d.cnt = st_q.rld;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
        if (rld_wr) st_d.rld = wr_val;
        if (cnt_wr) st_d.cnt = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rld_q = st_q.rld;
    assign cnt_q = st_q.cnt;

    // R5: word counter steps only on ticks
    a_r5_span_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0 && !cnt_wr) |=> cnt_q == $past(rld_q));
    a_r5_span_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0 && !cnt_wr) |=> cnt_q == $past(cnt_q) - 1'b1);
    a_r7_span_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/ssl_shift_core.sv
module ssl_shift_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          swap,
    input  logic          sin,
    input  logic          word_wr,
    input  logic          buf_wr,
    input  logic [DW-1:0] wr_val,
    output logic [DW-1:0] word_q,
    output logic [DW-1:0] buf_q
);

    typedef struct packed {
        logic [DW-1:0] word;
        logic [DW-1:0] bufw;
    } core_st_t;

    core_st_t    st_d, st_q;
    logic [DW-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        shifted = {sin, st_q.word[DW-1:1]};
        if (swap) begin
            st_d.word = st_q.bufw;
            st_d.bufw = shifted;
        end else if (tick) begin
            st_d.word = shifted;
        end
        if (word_wr) st_d.word = wr_val;
        if (buf_wr)  st_d.bufw = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_q = st_q.word;
    assign buf_q  = st_q.bufw;

    // R2: right shift with serial input at the top
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !swap && !word_wr) |=> word_q == {$past(sin), $past(word_q[DW-1:1])});
    // R6: whole-word exchange on wrap
    a_r6_swap_word: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !word_wr) |=> word_q == $past(buf_q));
    a_r6_swap_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !buf_wr) |=> buf_q == {$past(sin), $past(word_q[DW-1:1])});
    // R7: no movement without a tick
    a_r7_core_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !word_wr && !buf_wr) |=> ($stable(word_q) && $stable(buf_q)));
    // R8: software write wins over shift and swap
    a_r8_word_write: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr |=> word_q == $past(wr_val));

endmodule

// File: rtl/serial_shift_slice.sv
module serial_shift_slice #(
    parameter int WORD_W = ssl_pkg::WORD_W,
    parameter int RATE_W = ssl_pkg::RATE_W,
    parameter int SPAN_W = ssl_pkg::SPAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slice_en,
    input  logic              ser_in,
    output logic              ser_out,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata
);
    import ssl_pkg::*;

    localparam int RATE_PAD = WORD_W - RATE_W;
    localparam int SPAN_PAD = WORD_W - SPAN_W;

    reg_sel_e          sel;
    logic              tick, swap;
    logic [RATE_W-1:0] rate_rld, rate_cnt;
    logic [SPAN_W-1:0] span_rld, span_cnt;
    logic [WORD_W-1:0] word, bufw;

    assign sel = reg_sel_e'(cfg_addr);

    ssl_rate_div #(.CW(RATE_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (slice_en),
        .rld_wr (cfg_wr && sel == SEL_RATE_RLD),
        .cnt_wr (cfg_wr && sel == SEL_RATE_CNT),
        .wr_val (cfg_wdata[RATE_W-1:0]),
        .rld_q  (rate_rld),
        .cnt_q  (rate_cnt),
        .tick   (tick)
    );

    ssl_span_ctr #(.PW(SPAN_W)) u_span (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .rld_wr (cfg_wr && sel == SEL_SPAN_RLD),
        .cnt_wr (cfg_wr && sel == SEL_SPAN_CNT),
        .wr_val (cfg_wdata[SPAN_W-1:0]),
        .rld_q  (span_rld),
        .cnt_q  (span_cnt),
        .wrap   (swap)
    );

    ssl_shift_core #(.DW(WORD_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .swap    (swap),
        .sin     (ser_in),
        .word_wr (cfg_wr && sel == SEL_WORD),
        .buf_wr  (cfg_wr && sel == SEL_BUFFER),
        .wr_val  (cfg_wdata),
        .word_q  (word),
        .buf_q   (bufw)
    );

    assign ser_out = word[0];

    always_comb begin
        case (sel)
            SEL_WORD:     cfg_rdata = word;
            SEL_BUFFER:   cfg_rdata = bufw;
            SEL_RATE_RLD: cfg_rdata = {{RATE_PAD{1'b0}}, rate_rld};
            SEL_RATE_CNT: cfg_rdata = {{RATE_PAD{1'b0}}, rate_cnt};
            SEL_SPAN_RLD: cfg_rdata = {{SPAN_PAD{1'b0}}, span_rld};
            SEL_SPAN_CNT: cfg_rdata = {{SPAN_PAD{1'b0}}, span_cnt};
            default:      cfg_rdata = '0;
        endcase
    end

    // R5/R6: a swap only ever comes with a tick
    a_r6_swap_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        swap |-> tick);
    // R7: no ticks while disabled
    a_r7_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_en |-> !tick);
    // R3: serial output follows the shift word across edges
    a_r3_out_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && sel == SEL_WORD) |=> ser_out == $past(cfg_wdata[0]));

endmodule

// File: tb/serial_shift_slice_test.sv
module serial_shift_slice_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slice_en = 1'b0, ser_in = 1'b0, cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ser_out;
    logic [31:0] cfg_rdata;

    always #5 clk = ~clk;

    serial_shift_slice uut (
        .clk(clk), .rst_n(rst_n), .slice_en(slice_en), .ser_in(ser_in),
        .ser_out(ser_out), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit chk_on = 1'b0, done = 1'b0;

    // requirement-level model
    logic [31:0] m_word, m_buf;
    logic [11:0] m_rrld, m_rcnt;
    logic [7:0]  m_srld, m_scnt;

    function automatic logic [31:0] model_rd(logic [2:0] a);
        case (a)
            3'd0: return m_word;
            3'd1: return m_buf;
            3'd2: return {20'd0, m_rrld};
            3'd3: return {20'd0, m_rcnt};
            3'd4: return {24'd0, m_srld};
            3'd5: return {24'd0, m_scnt};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R6";
            3'd2: return "R9";
            3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = '0; m_buf = '0; m_rrld = '0; m_rcnt = '0; m_srld = '0; m_scnt = '0;
        end else begin
            automatic logic tk = slice_en && (m_rcnt == 0);
            automatic logic sw = tk && (m_scnt == 0);
            automatic logic [31:0] sh = {ser_in, m_word[31:1]};
            automatic logic [31:0] nw = m_word, nb = m_buf;
            automatic logic [11:0] nrc = m_rcnt, nrr = m_rrld;
            automatic logic [7:0]  nsc = m_scnt, nsr = m_srld;
            if (slice_en) nrc = (m_rcnt == 0) ? m_rrld : m_rcnt - 12'd1;
            if (tk) nsc = (m_scnt == 0) ? m_srld : m_scnt - 8'd1;
            if (sw) begin nw = m_buf; nb = sh; end
            else if (tk) nw = sh;
            if (cfg_wr) case (cfg_addr)
                3'd0: nw = cfg_wdata;
                3'd1: nb = cfg_wdata;
                3'd2: nrr = cfg_wdata[11:0];
                3'd3: nrc = cfg_wdata[11:0];
                3'd4: nsr = cfg_wdata[7:0];
                3'd5: nsc = cfg_wdata[7:0];
                default: ;
            endcase
            m_word = nw; m_buf = nb; m_rcnt = nrc; m_rrld = nrr; m_scnt = nsc; m_srld = nsr;
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // lockstep comparison, 3 ns after the falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            #3;
            check(tag_of(cfg_addr), cfg_rdata, model_rd(cfg_addr));
            check("R3", {31'd0, ser_out}, {31'd0, m_word[0]});
        end
    end

    task automatic cyc(logic en, logic wr, logic [2:0] a, logic [31:0] d, logic si);
        @(negedge clk);
        slice_en = en; cfg_wr = wr; cfg_addr = a; cfg_wdata = d; ser_in = si;
    endtask

    task automatic rd_check(logic en, logic [2:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        slice_en = en; cfg_wr = 1'b0; cfg_addr = a;
        #3;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 8; a++) rd_check(1'b0, a[2:0], 32'd0, "R1");
        check("R1", {31'd0, ser_out}, 32'd0);
        chk_on = 1'b1;

        // R4/R11: preset phase and rate
        cyc(0, 1, 3'd2, 32'd3, 0);
        cyc(0, 1, 3'd3, 32'd2, 0);
        cyc(0, 1, 3'd4, 32'd255, 0);
        cyc(0, 1, 3'd5, 32'd200, 0);
        cyc(0, 1, 3'd0, 32'd0, 0);
        cyc(1, 0, 3'd0, 32'd0, 1);
        cyc(1, 0, 3'd0, 32'd0, 1);
        rd_check(1, 3'd0, 32'h0000_0000, "R4");
        rd_check(1, 3'd0, 32'h8000_0000, "R11");
        for (int i = 0; i < 7; i++) cyc(1, 0, 3'd0, 32'd0, 1);
        rd_check(1, 3'd0, 32'hE000_0000, "R4");

        // R7: disabled lane holds
        for (int i = 0; i < 10; i++) cyc(0, 0, 3'd0, 32'd0, 1);
        rd_check(0, 3'd0, 32'hE000_0000, "R7");
        rd_check(0, 3'd3, 32'd2, "R7");
        rd_check(0, 3'd5, 32'd197, "R7");

        // R8: write beats shift in the same cycle
        cyc(0, 1, 3'd2, 32'd0, 0);
        cyc(0, 1, 3'd3, 32'd0, 0);
        cyc(1, 1, 3'd0, 32'h1234_5678, 1);
        rd_check(0, 3'd0, 32'h1234_5678, "R8");

        // R6: exchange on wrap
        cyc(0, 1, 3'd0, 32'hA5A5_A5A5, 0);
        cyc(0, 1, 3'd1, 32'h0F0F_0F0F, 0);
        cyc(0, 1, 3'd4, 32'd1, 0);
        cyc(0, 1, 3'd5, 32'd0, 0);
        cyc(1, 0, 3'd0, 32'd0, 1);
        rd_check(0, 3'd0, 32'h0F0F_0F0F, "R6");
        rd_check(0, 3'd1, 32'hD2D2_D2D2, "R6");
        rd_check(0, 3'd5, 32'd1, "R5");
        cyc(1, 0, 3'd0, 32'd0, 0);
        cyc(1, 0, 3'd0, 32'd0, 0);
        rd_check(0, 3'd0, 32'hD2D2_D2D2, "R6");
        rd_check(0, 3'd1, 32'h03C3_C3C3, "R6");

        // R9/R10: field widths and unused addresses
        cyc(0, 1, 3'd2, 32'hFFFF_FFFF, 0);
        rd_check(0, 3'd2, 32'h0000_0FFF, "R9");
        cyc(0, 1, 3'd4, 32'hFFFF_FFFF, 0);
        rd_check(0, 3'd4, 32'h0000_00FF, "R9");
        cyc(0, 1, 3'd6, 32'hFFFF_FFFF, 0);
        rd_check(0, 3'd6, 32'd0, "R10");
        rd_check(0, 3'd0, 32'hD2D2_D2D2, "R10");

        // random traffic checked in lockstep
        for (int i = 0; i < 4000; i++) begin
            automatic logic [2:0]  a = 3'($urandom % 8);
            automatic logic [31:0] d = $urandom;
            if ((a == 3'd2 || a == 3'd3) && ($urandom % 10 != 0)) d = d & 32'h7;
            if (a == 3'd4 || a == 3'd5) d = d & 32'hF;
            cyc(($urandom % 8) != 0, ($urandom % 6) == 0, a, d, 1'($urandom));
        end
        @(negedge clk);
        #4;
        finish_run();
    end

endmodule